// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This combinational datapath unit carries out the second byte of a two-byte prefixed opcode of an 8-bit processor on a single operand. The top two opcode bits pick one of four groups: rotate/shift, bit test, bit clear or bit set. The middle three bits give either the rotate kind or a bit index. The low three bits name the operand register. The surrounding core decodes that register, fetches the operand, and writes the result back when the unit raises its write enable.

The same unit also runs the four short accumulator rotates that take no prefix. These move data exactly like their prefixed versions, but they always clear the zero flag instead of deriving it from the result. A mode input picks between prefixed and accumulator operation. Flags come in and go out as a 4-bit vector, and the unit passes through any flag that the operation leaves alone.

Top module: `sru_unit`

## Requirements
- R1: The flag vectors are packed as bit 3 zero, bit 2 subtract, bit 1 half-carry and bit 0 carry. In prefixed mode, opcode bits 7..6 select the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Opcode bits 5..3 give the kind or bit index, and bits 2..0 do not affect the outputs.
- R2: Kind 0 rotates left circularly and kind 1 rotates right circularly. Carry receives the bit moved out: bit 7 on a left move, bit 0 on a right move.
- R3: Kind 2 rotates left through carry and kind 3 rotates right through carry. The incoming carry enters the vacated end bit, and the bit moved out becomes the new carry.
- R4: Kind 4 shifts left and fills bit 0 with zero. Kind 5 shifts right and keeps bit 7. Kind 7 shifts right and clears bit 7. In all three, carry receives the bit moved out.
- R5: Kind 6 exchanges the high and low nibbles and clears carry.
- R6: Every prefixed rotate/shift clears subtract and half-carry, sets zero exactly when the 8-bit result is 0x00, and asserts write enable.
- R7: In accumulator mode, kinds 0..3 produce the same result and carry as R2 and R3. They clear zero, subtract and half-carry and assert write enable. Opcode bits 7..6 and 2..0 are ignored.
- R8: In accumulator mode, kinds 4..7 are invalid. The unit then drives write enable low, returns the operand unchanged and leaves all flags unchanged.
- R9: Bit test sets zero when the selected bit is 0 and clears it otherwise. It sets half-carry, clears subtract, keeps carry, drives write enable low and returns the operand unchanged.
- R10: Bit clear and bit set force the selected bit to 0 or 1, leave every other bit unchanged, assert write enable and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Second opcode byte (group, kind/index, register field) |
| acc_mode | input | 1 | 1 selects the non-prefixed accumulator rotates |
| operand_in | input | 8 | Operand value supplied by the caller |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| result_out | output | 8 | New operand value |
| wr_en | output | 1 | Caller should write result_out back to the operand |
| flags_out | output | 4 | New flags {zero, subtract, half-carry, carry} |

## Verification
The sweep covers every opcode against every operand, with both carry states and changing patterns on the other flags. This exposes a through-carry rotate that ignores the old carry, an arithmetic shift right that loses bit 7, or a swap that keeps carry. Operands that become zero only after a shift, such as 0x80 shifted left or 0x01 shifted right, catch a zero flag taken from the input instead of the result. Accumulator-mode runs check that zero stays clear even for a zero result, and that kinds 4..7 write nothing. Bit-test runs with carry set catch a design that clears carry or writes the operand back.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } sh_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic flags_t mk_flags(logic z, logic n, logic h, logic c);
        flags_t f;
        f.z = z;
        f.n = n;
        f.h = h;
        f.c = c;
        return f;
    endfunction

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
#(
    parameter int IW  = 3,
    localparam int OPW = 2 + IW + 3
) (
    input  logic [OPW-1:0] op,
    input  logic           acc_mode,
    output grp_e           grp,
    output sh_e            kind,
    output logic [IW-1:0]  idx,
    output logic           acc_bad
);
    logic [IW-1:0] field;

    always_comb begin
        field   = op[IW+2:3];
        idx     = field;
        kind    = sh_e'(field[2:0]);
        grp     = acc_mode ? GRP_SHIFT : grp_e'(op[OPW-1:OPW-2]);
        acc_bad = acc_mode && field[2];
    end
endmodule

// File: rtl/sru_shift.sv
module sru_shift
    import sru_pkg::*;
#(
    parameter int DW = 8
) (
    input  sh_e           kind,
    input  logic [DW-1:0] val,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam int HW = DW / 2;

    always_comb begin
        res  = val;
        cout = 1'b0;
        unique case (kind)
            SH_RLC: begin
                res  = {val[DW-2:0], val[DW-1]};
                cout = val[DW-1];
            end
            SH_RRC: begin
                res  = {val[0], val[DW-1:1]};
                cout = val[0];
            end
            SH_RL: begin
                res  = {val[DW-2:0], cin};
                cout = val[DW-1];
            end
            SH_RR: begin
                res  = {cin, val[DW-1:1]};
                cout = val[0];
            end
            SH_SLA: begin
                res  = {val[DW-2:0], 1'b0};
                cout = val[DW-1];
            end
            SH_SRA: begin
                res  = {val[DW-1], val[DW-1:1]};
                cout = val[0];
            end
            SH_SWAP: begin
                res  = {val[HW-1:0], val[DW-1:HW]};
                cout = 1'b0;
            end
            SH_SRL: begin
                res  = {1'b0, val[DW-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sru_bitop.sv
module sru_bitop
    import sru_pkg::*;
#(
    parameter int DW = 8,
    localparam int IW = $clog2(DW)
) (
    input  grp_e          grp,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] res,
    output logic          hit
);
    logic [DW-1:0] sel;

    for (genvar i = 0; i < DW; i++) begin : g_sel
        assign sel[i] = (idx == IW'(i));
    end

    always_comb begin
        hit = |(val & sel);
        unique case (grp)
            GRP_CLR: res = val & ~sel;
            GRP_SET: res = val | sel;
            default: res = val;
        endcase
    end
endmodule

// File: rtl/sru_unit.sv
module sru_unit
    import sru_pkg::*;
#(
    parameter int DW = 8,
    localparam int IW  = $clog2(DW),
    localparam int OPW = 2 + IW + 3
) (
    input  logic [OPW-1:0] op_code,
    input  logic           acc_mode,
    input  logic [DW-1:0]  operand_in,
    input  logic [3:0]     flags_in,
    output logic [DW-1:0]  result_out,
    output logic           wr_en,
    output logic [3:0]     flags_out
);
    grp_e          grp;
    sh_e           kind;
    logic [IW-1:0] idx;
    logic          acc_bad;
    logic [DW-1:0] sh_res, bit_res;
    logic          sh_c, hit;
    flags_t        fi, fo;

    assign fi = flags_t'(flags_in);

    sru_decode #(.IW(IW)) u_dec (
        .op(op_code), .acc_mode(acc_mode),
        .grp(grp), .kind(kind), .idx(idx), .acc_bad(acc_bad)
    );

    sru_shift #(.DW(DW)) u_sh (
        .kind(kind), .val(operand_in), .cin(fi.c),
        .res(sh_res), .cout(sh_c)
    );

    sru_bitop #(.DW(DW)) u_bit (
        .grp(grp), .idx(idx), .val(operand_in),
        .res(bit_res), .hit(hit)
    );

    always_comb begin
        result_out = operand_in;
        wr_en      = 1'b0;
        fo         = fi;
        if (acc_mode) begin
            if (!acc_bad) begin
                result_out = sh_res;
                wr_en      = 1'b1;
                fo         = mk_flags(1'b0, 1'b0, 1'b0, sh_c);
            end
        end else begin
            unique case (grp)
                GRP_SHIFT: begin
                    result_out = sh_res;
                    wr_en      = 1'b1;
                    fo         = mk_flags(sh_res == '0, 1'b0, 1'b0, sh_c);
                end
                GRP_TEST: begin
                    fo = mk_flags(!hit, 1'b0, 1'b1, fi.c);
                end
                default: begin
                    result_out = bit_res;
                    wr_en      = 1'b1;
                end
            endcase
        end
        flags_out = fo;
    end
endmodule

// File: rtl/sru_unit_chk.sv
module sru_unit_chk #(
    parameter int DW = 8,
    localparam int IW  = $clog2(DW),
    localparam int OPW = 2 + IW + 3
) (
    input logic [OPW-1:0] op_code,
    input logic           acc_mode,
    input logic [DW-1:0]  operand_in,
    input logic [3:0]     flags_in,
    input logic [DW-1:0]  result_out,
    input logic           wr_en,
    input logic [3:0]     flags_out
);
    logic [1:0] g;
    assign g = op_code[OPW-1:OPW-2];

    always_comb begin
        if (!acc_mode && g == 2'b00) begin
            // R6
            shift_nh_clear_chk: assert (flags_out[2:1] == 2'b00 && wr_en);
        end
        if (!acc_mode && g == 2'b01) begin
            // R9
            test_no_write_chk: assert (!wr_en && result_out == operand_in
                                       && flags_out[0] == flags_in[0]);
        end
        if (!acc_mode && g[1]) begin
            // R10
            bitmod_flags_chk: assert (flags_out == flags_in && wr_en
                                      && $countones(result_out ^ operand_in) <= 1);
        end
        if (acc_mode && !op_code[5]) begin
            // R7
            acc_zero_clear_chk: assert (flags_out[3:1] == 3'b000 && wr_en);
        end
        if (acc_mode && op_code[5]) begin
            // R8
            acc_invalid_chk: assert (!wr_en && flags_out == flags_in
                                     && result_out == operand_in);
        end
    end
endmodule

bind sru_unit sru_unit_chk #(.DW(DW)) u_chk (
    .op_code(op_code), .acc_mode(acc_mode), .operand_in(operand_in),
    .flags_in(flags_in), .result_out(result_out), .wr_en(wr_en),
    .flags_out(flags_out)
);

// File: tb/sim_sru_unit.sv
module sim_sru_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_code = 8'h00;
    logic       acc_mode = 1'b0;
    logic [7:0] operand_in = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic [7:0] result_out;
    logic       wr_en;
    logic [3:0] flags_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sru_unit u0 (
        .op_code(op_code), .acc_mode(acc_mode), .operand_in(operand_in),
        .flags_in(flags_in), .result_out(result_out), .wr_en(wr_en),
        .flags_out(flags_out)
    );

    // reference: returns {result[7:0], wr, flags[3:0]}
    function automatic logic [12:0] model(input logic [7:0] op, input logic m,
                                          input logic [7:0] v, input logic [3:0] f,
                                          output string tag);
        logic [7:0] r;
        logic c, w;
        logic [3:0] fo;
        int k;
        k = int'(op[5:3]);
        c = f[0];
        r = v;
        w = 0;
        fo = f;
        if (m || op[7:6] == 2'b00) begin
            case (k)
                0: begin r = (v << 1) | (v >> 7); c = v[7]; tag = "R2"; end
                1: begin r = (v >> 1) | (v << 7); c = v[0]; tag = "R2"; end
                2: begin r = (v << 1) | {7'd0, f[0]}; c = v[7]; tag = "R3"; end
                3: begin r = (v >> 1) | {f[0], 7'd0}; c = v[0]; tag = "R3"; end
                4: begin r = v << 1; c = v[7]; tag = "R4"; end
                5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; tag = "R4"; end
                6: begin r = {v[3:0], v[7:4]}; c = 0; tag = "R5"; end
                default: begin r = v >> 1; c = v[0]; tag = "R4"; end
            endcase
            if (m) begin
                if (k >= 4) begin
                    r = v; w = 0; fo = f; tag = "R8";
                end else begin
                    w = 1; fo = {3'b000, c}; tag = {tag, "/R7"};
                end
            end else begin
                w = 1; fo = {(r == 8'h00), 2'b00, c}; tag = {tag, "/R6"};
            end
        end else if (op[7:6] == 2'b01) begin
            fo = {~v[k], 1'b0, 1'b1, f[0]};
            tag = "R9";
        end else begin
            r = v;
            r[k] = op[6];
            w = 1;
            tag = "R10";
        end
        return {r, w, fo};
    endfunction

    task automatic apply_chk(input logic [7:0] op, input logic m,
                             input logic [7:0] v, input logic [3:0] f);
        logic [12:0] exp;
        string tag;
        op_code = op; acc_mode = m; operand_in = v; flags_in = f;
        #2;
        exp = model(op, m, v, f, tag);
        checks++;
        if ({result_out, wr_en, flags_out} !== exp) begin
            failures++;
            if (failures <= 20)
                $display("FAIL %s op=%02h acc=%0d v=%02h f=%h: got res=%02h wr=%0d fl=%h exp res=%02h wr=%0d fl=%h",
                         tag, op, m, v, f, result_out, wr_en, flags_out,
                         exp[12:5], exp[4], exp[3:0]);
        end
        #2;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R6 reset state: RLC of zero gives zero result, zero flag set
        checks++;
        if ({result_out, wr_en, flags_out} !== {8'h00, 1'b1, 4'b1000}) begin
            failures++;
            $display("FAIL R6 reset-state got %02h %0d %h exp 00 1 8",
                     result_out, wr_en, flags_out);
        end
        rst = 1'b0;
        // R1..R6, R9, R10: full prefixed sweep, both carry states
        for (int op = 0; op < 256; op++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    apply_chk(8'(op), 1'b0, 8'(v),
                              {op[0] ^ v[0], v[1], op[1] ^ v[2], c[0]});
        // R7, R8: accumulator mode, noisy group/register bits (R1 field ignored)
        for (int k = 0; k < 8; k++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    apply_chk({v[1:0], 3'(k), v[4:2]}, 1'b1, 8'(v),
                              {v[5], v[6], v[7], c[0]});
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule